// File: doc/BRIEF.md
# Three-Tier Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core and turns the winner into a forced long call. Each programmable source has a request flag, an enable bit and a priority bit that puts it in the low or the high tier. A power-fail request sits alone in a fixed top tier above both, with its own enable and its own vector. A global enable gates every programmable source but leaves power-fail alone.

Flags are captured into a sample register on each machine-cycle strobe. A combinational selector works from those samples during the rest of the machine cycle. At the next strobe the core reports whether the instruction is ending, is a return-from-interrupt, or is writing an interrupt control register. If none of these blocks it and the winner outranks every level already in service, the block raises a one-clock long-call request with the vector and marks that level in service. A return-from-interrupt releases the highest level in service.

Software may write the flags to fake or cancel requests. One flag belongs to the real-time clock and accepts only clearing from software. Level-sensitive sources copy their pin into the flag and take no write at all.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, flag_o, isr_o and lcall_o are all zero.
- R2: A software flag write (sw_flag_we_i) loads sw_flag_wdata_i into every edge-type flag on the next clock, and a hardware pulse on irq_i sets the flag. The hardware pulse wins over a write in the same clock.
- R3: The real-time-clock flag (index RTC_IDX, default 5) ignores software writes of 1, is cleared by a software write of 0 and is set by irq_i.
- R4: A level-sensitive flag (LEVEL_MASK bit set, default index 0) equals irq_i one clock later, and software writes have no effect on it.
- R5: A request that is pending and enabled when the flags are sampled at strobe k is acknowledged at strobe k+1. lcall_o is high for exactly one clock after that edge, vec_o = 0x0003 + 8·n for source n, and the matching isr_o bit is set (bit 0 low, bit 1 high, bit 2 power-fail).
- R6: Within one tier the lowest source index wins. A high-tier source (irq_prio_i bit = 1) beats any low-tier source.
- R7: With glb_en_i low, no programmable source is acknowledged. An enabled power-fail request is still taken with vector PF_VEC (default 0x0033) and sets isr_o bit 2.
- R8: No acknowledge occurs at a strobe where last_cyc_i is low, reti_i is high, or ctl_wr_i is high.
- R9: A request is accepted only if its tier is strictly above the highest tier in isr_o.
- R10: A strobe with reti_i and last_cyc_i both high clears the highest set isr_o bit.
- R11: Clearing a flag while the acknowledge is blocked, followed by one more strobe, cancels the request. Clearing it after the acknowledge leaves isr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Hardware set pulses (edge type) or pin levels (level type) |
| sw_flag_we_i | input | 1 | Software flag write strobe |
| sw_flag_wdata_i | input | N_SRC | Software flag write data |
| flag_o | output | N_SRC | Current request flags |
| irq_en_i | input | N_SRC | Per-source enable |
| irq_prio_i | input | N_SRC | Per-source tier: 1 high, 0 low |
| glb_en_i | input | 1 | Global enable for programmable sources |
| pf_req_i | input | 1 | Power-fail request flag |
| pf_en_i | input | 1 | Power-fail enable |
| mcyc_i | input | 1 | Machine-cycle strobe |
| last_cyc_i | input | 1 | Current cycle ends the instruction |
| reti_i | input | 1 | Return-from-interrupt in progress |
| ctl_wr_i | input | 1 | Write to interrupt enable or priority register |
| lcall_o | output | 1 | One-clock forced long-call request |
| vec_o | output | VEC_W | Vector of the accepted request |
| isr_o | output | 3 | In-service tiers: bit 0 low, bit 1 high, bit 2 power-fail |

## Verification
The hardest case to reach is cancellation. The acknowledge decision uses samples taken one strobe earlier, so clearing a flag does not stop an acknowledge that is already queued. The stimulus holds the acknowledge off with a strobe on a non-final cycle, clears the flag, and then spends one more blocked strobe to resample before it opens the gate. Nesting all three tiers is also hard. The bench builds it step by step by retuning priority bits while lower service levels stay active. It then unwinds the tiers with return strobes, after first clearing the flags so the released levels are not taken again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_LOW  = 2'd1,
    RK_HIGH = 2'd2,
    RK_TOP  = 2'd3
  } rank_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int          N_SRC      = 6,
  parameter int          RTC_IDX    = 5,
  parameter logic [31:0] LEVEL_MASK = 32'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_i,
  input  logic             sw_we_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    logic bit_q;
    assign flag_o[g] = bit_q;
    if (LEVEL_MASK[g]) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= hw_i[g];
      AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> bit_q == $past(hw_i[g])); // R4
    end else if (g == RTC_IDX) begin : g_rtc
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      bit_q <= 1'b0;
        else if (hw_i[g]) bit_q <= 1'b1;
        else if (sw_we_i) bit_q <= bit_q & sw_wdata_i[g]; // write 1 ignored
      AST_RTC_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_we_i && !hw_i[g] && !bit_q) |=> !bit_q); // R3
    end else begin : g_edge
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)      bit_q <= 1'b0;
        else if (hw_i[g]) bit_q <= 1'b1;
        else if (sw_we_i) bit_q <= sw_wdata_i[g];
      AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_i[g] |=> bit_q); // R2
    end
  end
endmodule

// File: rtl/irq_sel.sv
module irq_sel
  import irq_pkg::*;
#(
  parameter int          N_SRC    = 6,
  parameter int          VEC_W    = 16,
  parameter int          VEC_BASE = 3,
  parameter int          VEC_STEP = 8,
  parameter logic [15:0] PF_VEC   = 16'h0033
) (
  input  logic [N_SRC-1:0] samp_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             gen_i,
  input  logic             pf_i,
  input  logic             pf_en_i,
  output logic             vld_o,
  output rank_e            rank_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] hi_req, lo_req;
  logic [IW-1:0]    hi_idx, lo_idx;

  assign hi_req = samp_i & en_i &  prio_i & {N_SRC{gen_i}};
  assign lo_req = samp_i & en_i & ~prio_i & {N_SRC{gen_i}};

  // natural order: lowest index wins inside a tier
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_req[i]) hi_idx = IW'(i);
      if (lo_req[i]) lo_idx = IW'(i);
    end
  end

  always_comb begin
    vld_o  = 1'b1;
    rank_o = RK_NONE;
    vec_o  = '0;
    if (pf_i && pf_en_i) begin
      rank_o = RK_TOP;
      vec_o  = VEC_W'(PF_VEC);
    end else if (|hi_req) begin
      rank_o = RK_HIGH;
      vec_o  = VEC_W'(VEC_BASE + VEC_STEP * int'(hi_idx));
    end else if (|lo_req) begin
      rank_o = RK_LOW;
      vec_o  = VEC_W'(VEC_BASE + VEC_STEP * int'(lo_idx));
    end else begin
      vld_o  = 1'b0;
    end
  end
endmodule

// File: rtl/irq_track.sv
module irq_track
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  rank_e      rank_i,
  input  logic       rel_i,
  output logic [2:0] isr_o,
  output rank_e      cur_o
);
  logic [2:0] isr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else if (ack_i) begin
      case (rank_i)
        RK_LOW:  isr_q[0] <= 1'b1;
        RK_HIGH: isr_q[1] <= 1'b1;
        RK_TOP:  isr_q[2] <= 1'b1;
        default: ;
      endcase
    end else if (rel_i) begin
      if      (isr_q[2]) isr_q[2] <= 1'b0;
      else if (isr_q[1]) isr_q[1] <= 1'b0;
      else               isr_q[0] <= 1'b0;
    end
  end

  always_comb begin
    if      (isr_q[2]) cur_o = RK_TOP;
    else if (isr_q[1]) cur_o = RK_HIGH;
    else if (isr_q[0]) cur_o = RK_LOW;
    else               cur_o = RK_NONE;
  end

  assign isr_o = isr_q;

  AST_ACK_ADDS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> $countones(isr_q) == $countones($past(isr_q)) + 1); // R9
  AST_RETI_DROPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !ack_i && isr_q != 3'b000) |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R10
  AST_RETI_TOP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !ack_i && isr_q[2]) |=> !isr_q[2] && isr_q[1:0] == $past(isr_q[1:0])); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int          N_SRC      = 6,
  parameter int          VEC_W      = 16,
  parameter int          RTC_IDX    = 5,
  parameter logic [31:0] LEVEL_MASK = 32'h1,
  parameter logic [15:0] PF_VEC     = 16'h0033
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             sw_flag_we_i,
  input  logic [N_SRC-1:0] sw_flag_wdata_i,
  output logic [N_SRC-1:0] flag_o,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [N_SRC-1:0] irq_prio_i,
  input  logic             glb_en_i,
  input  logic             pf_req_i,
  input  logic             pf_en_i,
  input  logic             mcyc_i,
  input  logic             last_cyc_i,
  input  logic             reti_i,
  input  logic             ctl_wr_i,
  output logic             lcall_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [2:0]       isr_o
);
  logic [N_SRC-1:0] flags, samp_q;
  logic             pf_samp_q;
  logic             win_vld, ack, rel;
  rank_e            win_rank, cur_rank;
  logic [VEC_W-1:0] win_vec;
  logic             lcall_q;
  logic [VEC_W-1:0] vec_q;

  irq_flags #(.N_SRC(N_SRC), .RTC_IDX(RTC_IDX), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk_i, .rst_ni,
    .hw_i(irq_i), .sw_we_i(sw_flag_we_i), .sw_wdata_i(sw_flag_wdata_i),
    .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q    <= '0;
      pf_samp_q <= 1'b0;
    end else if (mcyc_i) begin
      samp_q    <= flags;
      pf_samp_q <= pf_req_i;
    end
  end

  irq_sel #(.N_SRC(N_SRC), .VEC_W(VEC_W), .PF_VEC(PF_VEC)) u_sel (
    .samp_i(samp_q), .en_i(irq_en_i), .prio_i(irq_prio_i), .gen_i(glb_en_i),
    .pf_i(pf_samp_q), .pf_en_i(pf_en_i),
    .vld_o(win_vld), .rank_o(win_rank), .vec_o(win_vec)
  );

  // acknowledge uses last strobe's samples; blocked mid-instruction, on RETI and control writes
  assign ack = mcyc_i && last_cyc_i && !reti_i && !ctl_wr_i && win_vld && (win_rank > cur_rank);
  assign rel = mcyc_i && last_cyc_i && reti_i;

  irq_track u_track (
    .clk_i, .rst_ni,
    .ack_i(ack), .rank_i(win_rank), .rel_i(rel),
    .isr_o(isr_o), .cur_o(cur_rank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcall_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      lcall_q <= ack;
      if (ack) vec_q <= win_vec;
    end
  end

  assign flag_o  = flags;
  assign lcall_o = lcall_q;
  assign vec_o   = vec_q;

  AST_LCALL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcall_q |-> $past(mcyc_i && last_cyc_i && !reti_i && !ctl_wr_i)); // R8
  AST_LCALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcall_q |=> !lcall_q || $past(mcyc_i)); // R5
  AST_LCALL_MARKS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcall_q |-> isr_o != 3'b000); // R5
  AST_NO_GEN_NO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !glb_en_i) |=> isr_o[2]); // R7
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic [N-1:0] irq_i, sw_wdata, flag_o, irq_en, irq_prio;
  logic         sw_we, glb_en, pf_req, pf_en, mcyc, last_cyc, reti, ctl_wr;
  logic         lcall_o;
  logic [15:0]  vec_o;
  logic [2:0]   isr_o;
  int           n_chk = 0, n_fail = 0, n_cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i),
    .sw_flag_we_i(sw_we), .sw_flag_wdata_i(sw_wdata), .flag_o(flag_o),
    .irq_en_i(irq_en), .irq_prio_i(irq_prio), .glb_en_i(glb_en),
    .pf_req_i(pf_req), .pf_en_i(pf_en), .mcyc_i(mcyc), .last_cyc_i(last_cyc),
    .reti_i(reti), .ctl_wr_i(ctl_wr), .lcall_o(lcall_o), .vec_o(vec_o), .isr_o(isr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; irq_i = '0; sw_we = 0; sw_wdata = '0;
    irq_en = '1; irq_prio = '0; glb_en = 1; pf_req = 0; pf_en = 1;
    mcyc = 0; last_cyc = 1; reti = 0; ctl_wr = 0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic sw_write(input logic [N-1:0] d);
    sw_we = 1; sw_wdata = d;
    tick();
    sw_we = 0;
  endtask

  task automatic strobe(input logic lst, input logic rt, input logic cw);
    mcyc = 1; last_cyc = lst; reti = rt; ctl_wr = cw;
    tick();
    mcyc = 0; last_cyc = 1; reti = 0; ctl_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 isr", 32'(isr_o), 0);
    chk("R1 lcall", 32'(lcall_o), 0);
  endtask

  task automatic t_flags();
    do_reset();
    sw_write('1);
    chk("R2 edge flags set by sw", 32'(flag_o[4:1]), 32'hF);
    chk("R3 rtc ignores sw 1", 32'(flag_o[5]), 0);
    chk("R4 level ignores sw", 32'(flag_o[0]), 0);
    irq_i[5] = 1; sw_we = 1; sw_wdata = '0;
    tick();
    irq_i[5] = 0; sw_we = 0;
    chk("R3 hw sets rtc over write", 32'(flag_o[5]), 1);
    chk("R2 sw clears edge flags", 32'(flag_o[4:1]), 0);
    sw_write('0);
    chk("R3 sw 0 clears rtc", 32'(flag_o[5]), 0);
    irq_i[0] = 1;
    tick();
    chk("R4 level follows pin high", 32'(flag_o[0]), 1);
    sw_write('0);
    chk("R4 sw 0 no effect", 32'(flag_o[0]), 1);
    irq_i[0] = 0;
    tick();
    chk("R4 level follows pin low", 32'(flag_o[0]), 0);
  endtask

  task automatic t_ack();
    do_reset();
    sw_write(6'b000100);
    strobe(1, 0, 0);
    chk("R5 no ack at sampling strobe", 32'(lcall_o), 0);
    strobe(1, 0, 0);
    chk("R5 ack next strobe", 32'(lcall_o), 1);
    chk("R5 vector src2", 32'(vec_o), 32'h13);
    chk("R5 isr low", 32'(isr_o), 32'b001);
    tick();
    chk("R5 lcall one clock", 32'(lcall_o), 0);
  endtask

  task automatic t_natural();
    do_reset();
    sw_write(6'b001010);
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R6 lowest index wins", 32'(vec_o), 32'h0B);
    do_reset();
    irq_prio = 6'b001000;
    sw_write(6'b001010);
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R6 high tier wins", 32'(vec_o), 32'h1B);
    chk("R6 isr high", 32'(isr_o), 32'b010);
  endtask

  task automatic t_gate();
    do_reset();
    glb_en = 0;
    sw_write(6'b000100);
    strobe(1, 0, 0); strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R7 global enable gates", 32'(isr_o), 0);
    pf_req = 1;
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R7 power-fail taken", 32'(lcall_o), 1);
    chk("R7 power-fail vector", 32'(vec_o), 32'h33);
    chk("R7 isr top", 32'(isr_o), 32'b100);
  endtask

  task automatic t_block();
    do_reset();
    sw_write(6'b000100);
    strobe(1, 0, 0);
    strobe(0, 0, 0);
    chk("R8 not last cycle", 32'(lcall_o), 0);
    strobe(1, 1, 0);
    chk("R8 reti blocks", 32'(lcall_o), 0);
    strobe(1, 0, 1);
    chk("R8 ctl write blocks", 32'(lcall_o), 0);
    chk("R8 isr empty", 32'(isr_o), 0);
    strobe(1, 0, 0);
    chk("R8 unblocked ack", 32'(lcall_o), 1);
  endtask

  task automatic t_preempt();
    do_reset();
    sw_write(6'b000100);
    strobe(1, 0, 0); strobe(1, 0, 0);
    sw_write(6'b010100);
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R9 equal low no preempt", 32'(isr_o), 32'b001);
    irq_prio = 6'b010000;
    strobe(1, 0, 0);
    chk("R9 high preempts low", 32'(vec_o), 32'h23);
    chk("R9 isr low+high", 32'(isr_o), 32'b011);
    irq_prio = 6'b010010;
    sw_write(6'b010110);
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R9 equal high no preempt", 32'(isr_o), 32'b011);
    pf_req = 1;
    strobe(1, 0, 0); strobe(1, 0, 0);
    chk("R9 pf preempts high", 32'(isr_o), 32'b111);
    pf_req = 0;
    sw_write('0);
    strobe(1, 1, 0);
    chk("R10 reti clears top", 32'(isr_o), 32'b011);
    strobe(1, 1, 0);
    chk("R10 reti clears high", 32'(isr_o), 32'b001);
    strobe(0, 1, 0);
    chk("R10 reti needs last cycle", 32'(isr_o), 32'b001);
    strobe(1, 1, 0);
    chk("R10 reti clears low", 32'(isr_o), 0);
    strobe(1, 0, 0);
    chk("R10 no retake after clear", 32'(lcall_o), 0);
  endtask

  task automatic t_cancel();
    do_reset();
    sw_write(6'b000100);
    strobe(1, 0, 0);
    strobe(0, 0, 0);
    sw_write('0);
    strobe(0, 0, 0);
    strobe(1, 0, 0);
    chk("R11 cancelled no lcall", 32'(lcall_o), 0);
    chk("R11 cancelled isr", 32'(isr_o), 0);
    sw_write(6'b000100);
    strobe(1, 0, 0); strobe(1, 0, 0);
    sw_write('0);
    strobe(1, 0, 0);
    chk("R11 clear after ack keeps isr", 32'(isr_o), 32'b001);
  endtask

  initial begin
    t_reset();
    t_flags();
    t_ack();
    t_natural();
    t_gate();
    t_block();
    t_preempt();
    t_cancel();
    report();
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
      report();
    end
  end
endmodule